// File: doc/BRIEF.md
# Contrast, Brightness, Hue and Saturation Adjuster

This block is a streaming pixel processor. It accepts one 8-bit RGB pixel per clock, together with vertical sync, horizontal sync and data-enable. It converts the pixel to a luma/chroma form that carries no black-level or mid-scale offsets. This makes luma zero for black and both chroma components zero for grey.

In that zero-centred space the block applies four adjustments:
- luma is scaled by a contrast gain and then shifted by a signed brightness step;
- the chroma pair is rotated through a hue angle of up to thirty degrees either way;
- the rotated chroma is scaled by a saturation gain.

The result is converted back to RGB and clamped to the 8-bit range. The three timing flags travel through a register chain of the same length as the pixel path, so they stay aligned with the pixels they qualify.

The adjuster sits between a video receiver and a transmitter, and its four control codes are driven from slow user settings. Coefficients are signed fixed point with ten fractional bits. Every scaled product is rounded to nearest before the fractional bits are dropped. The sine and cosine values used for the hue rotation are generated at elaboration by a constant function, with one entry per hue code.

Top module: `cbhs_adjuster`

## Requirements
- R1: Forward conversion (Q10 coefficients, rounded) gives luma = 0.2568·R + 0.5041·G + 0.0979·B. It gives Cb = 0.4392·B − 0.1482·R − 0.2910·G and Cr = 0.4392·R − 0.3678·G − 0.0714·B, with no offsets added. A pixel with R = G = B yields exactly zero Cb and Cr.
- R2: Contrast code c (unsigned, 1 integer and 7 fractional bits) multiplies luma by c/128, so code 128 leaves luma unchanged.
- R3: Brightness (6-bit two's complement, −32..+31) is added to luma after the contrast gain. Code 0 adds nothing.
- R4: Hue code h selects angle θ = (h − 128)·30/128 degrees. The rotation is Cb' = Cb·cosθ + Cr·sinθ and Cr' = Cr·cosθ − Cb·sinθ, and code 128 leaves chroma unchanged.
- R5: Saturation code s (1 integer and 7 fractional bits) multiplies both rotated chroma components by s/128. Code 0 removes all colour.
- R6: Inverse conversion gives R = 1.1644·Y + 1.5960·Cr, G = 1.1644·Y − 0.3918·Cb − 0.8130·Cr and B = 1.1644·Y + 2.0172·Cb. Each output channel lies within a few codes of the real-valued result of R1 to R6.
- R7: Each output channel is clamped to 0..255. Results above 255 give 255 and results below 0 give 0.
- R8: Pixel latency from input to output is exactly 4 clock cycles. Vsync, hsync and DE reach their outputs with the same 4-cycle delay.
- R9: While rst_ni is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| red_i | input | 8 | Red sample in |
| grn_i | input | 8 | Green sample in |
| blu_i | input | 8 | Blue sample in |
| vsync_i | input | 1 | Vertical sync in |
| hsync_i | input | 1 | Horizontal sync in |
| de_i | input | 1 | Data enable in |
| contrast_i | input | 8 | Luma gain code, 128 = unity |
| bright_i | input | 6 | Signed luma offset |
| hue_i | input | 8 | Hue angle code, 128 = zero degrees |
| sat_i | input | 8 | Chroma gain code, 128 = unity |
| red_o | output | 8 | Red sample out |
| grn_o | output | 8 | Green sample out |
| blu_o | output | 8 | Blue sample out |
| vsync_o | output | 1 | Delayed vertical sync |
| hsync_o | output | 1 | Delayed horizontal sync |
| de_o | output | 1 | Delayed data enable |

## Verification
Each stage reads the control code it needs in the cycle the pixel passes through it. The properties on unity contrast, zero hue and zero saturation therefore relate a stage's input to its output one cycle later, and they assume only that the code is valid in that cycle. Outside a pixel's four-cycle flight, the controls are treated as slowly changing settings. For that reason the stimulus sets every control and pixel together on a falling edge and holds them for the whole latency before it samples the outputs. The latency scenario changes only the pixel and the timing flags on a single edge, with the controls held constant, so that the edge at which the output changes can be located exactly.

// File: rtl/cbhs_pkg.sv
package cbhs_pkg;
  localparam int COEF_FRAC   = 10;
  localparam int GAIN_FRAC   = 7;
  localparam int HUE_MAX_DEG = 30;
  localparam longint PI_Q20  = 64'sd3294199;

  function automatic int rnd_sh(input int a, input int sh);
    return (a + (1 <<< (sh - 1))) >>> sh;
  endfunction

  // Q10 sine or cosine of the hue angle for a code; Taylor series in Q20
  function automatic int trig_q(input int code, input int half, input bit want_sin);
    longint x, x2, x3, x4, x5, x6, v;
    x  = (longint'(code - half) * HUE_MAX_DEG * PI_Q20) / (longint'(half) * 180);
    x2 = (x * x) >>> 20;
    x3 = (x2 * x) >>> 20;
    x4 = (x2 * x2) >>> 20;
    x5 = (x4 * x) >>> 20;
    x6 = (x4 * x2) >>> 20;
    if (want_sin) v = x - x3 / 6 + x5 / 120;
    else          v = (64'sd1 <<< 20) - x2 / 2 + x4 / 24 - x6 / 720;
    return int'((v + 64'sd512) >>> 10);
  endfunction
endpackage

// File: rtl/cbhs_rgb2ycc.sv
module cbhs_rgb2ycc import cbhs_pkg::*; #(
  parameter int PIX_W = 8,
  parameter int YW    = 11,
  parameter int CW    = 10
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [PIX_W-1:0]     r_i,
  input  logic [PIX_W-1:0]     g_i,
  input  logic [PIX_W-1:0]     b_i,
  output logic signed [YW-1:0] y_o,
  output logic signed [CW-1:0] cb_o,
  output logic signed [CW-1:0] cr_o
);
  localparam int KYR = 263, KYG = 516, KYB = 100;
  localparam int KBR = 152, KBG = 298, KBB = 450;
  localparam int KRR = 450, KRG = 377, KRB = 73;

  int y_n, cb_n, cr_n;
  always_comb begin
    y_n  = rnd_sh( KYR*int'(r_i) + KYG*int'(g_i) + KYB*int'(b_i), COEF_FRAC);
    cb_n = rnd_sh(-KBR*int'(r_i) - KBG*int'(g_i) + KBB*int'(b_i), COEF_FRAC);
    cr_n = rnd_sh( KRR*int'(r_i) - KRG*int'(g_i) - KRB*int'(b_i), COEF_FRAC);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_o <= '0; cb_o <= '0; cr_o <= '0;
    end else begin
      y_o <= YW'(y_n); cb_o <= CW'(cb_n); cr_o <= CW'(cr_n);
    end
  end

  AST_GREY_NO_CHROMA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_i == g_i && g_i == b_i) |=> (cb_o == 0 && cr_o == 0)); // R1
endmodule

// File: rtl/cbhs_luma_hue.sv
module cbhs_luma_hue import cbhs_pkg::*; #(
  parameter int YW     = 11,
  parameter int CW     = 10,
  parameter int CODE_W = 8,
  parameter int BRI_W  = 6,
  parameter int TW     = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [YW-1:0] y_i,
  input  logic signed [CW-1:0] cb_i,
  input  logic signed [CW-1:0] cr_i,
  input  logic [CODE_W-1:0]    contrast_i,
  input  logic [BRI_W-1:0]     bright_i,
  input  logic [CODE_W-1:0]    hue_i,
  output logic signed [YW-1:0] y_o,
  output logic signed [CW-1:0] cb_o,
  output logic signed [CW-1:0] cr_o
);
  localparam int DEPTH = 1 << CODE_W;
  localparam int HALF  = DEPTH / 2;
  localparam logic [CODE_W-1:0] HUE_ZERO = CODE_W'(HALF);
  localparam logic [CODE_W-1:0] UNITY    = CODE_W'(1 << GAIN_FRAC);

  logic signed [TW-1:0] sin_tab [DEPTH];
  logic signed [TW-1:0] cos_tab [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_trig
    localparam int SV = trig_q(k, HALF, 1'b1);
    localparam int CV = trig_q(k, HALF, 1'b0);
    assign sin_tab[k] = TW'(SV);
    assign cos_tab[k] = TW'(CV);
  end

  int y_n, cb_n, cr_n, s_v, c_v;
  always_comb begin
    s_v  = int'(sin_tab[hue_i]);
    c_v  = int'(cos_tab[hue_i]);
    y_n  = rnd_sh(int'(y_i) * int'(contrast_i), GAIN_FRAC) + int'($signed(bright_i));
    cb_n = rnd_sh(int'(cb_i) * c_v + int'(cr_i) * s_v, COEF_FRAC);
    cr_n = rnd_sh(int'(cr_i) * c_v - int'(cb_i) * s_v, COEF_FRAC);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_o <= '0; cb_o <= '0; cr_o <= '0;
    end else begin
      y_o <= YW'(y_n); cb_o <= CW'(cb_n); cr_o <= CW'(cr_n);
    end
  end

  AST_LUMA_UNITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (contrast_i == UNITY && bright_i == '0) |=> (y_o == $past(y_i))); // R2
  AST_HUE_ZERO_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hue_i == HUE_ZERO) |=> (cb_o == $past(cb_i) && cr_o == $past(cr_i))); // R4
endmodule

// File: rtl/cbhs_sat.sv
module cbhs_sat import cbhs_pkg::*; #(
  parameter int YW     = 11,
  parameter int CW     = 10,
  parameter int CODE_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [YW-1:0] y_i,
  input  logic signed [CW-1:0] cb_i,
  input  logic signed [CW-1:0] cr_i,
  input  logic [CODE_W-1:0]    sat_i,
  output logic signed [YW-1:0] y_o,
  output logic signed [CW-1:0] cb_o,
  output logic signed [CW-1:0] cr_o
);
  int cb_n, cr_n;
  always_comb begin
    cb_n = rnd_sh(int'(cb_i) * int'(sat_i), GAIN_FRAC);
    cr_n = rnd_sh(int'(cr_i) * int'(sat_i), GAIN_FRAC);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_o <= '0; cb_o <= '0; cr_o <= '0;
    end else begin
      y_o <= y_i; cb_o <= CW'(cb_n); cr_o <= CW'(cr_n);
    end
  end

  AST_SAT_ZERO_GREY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat_i == '0) |=> (cb_o == 0 && cr_o == 0)); // R5
endmodule

// File: rtl/cbhs_ycc2rgb.sv
module cbhs_ycc2rgb import cbhs_pkg::*; #(
  parameter int PIX_W = 8,
  parameter int YW    = 11,
  parameter int CW    = 10
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [YW-1:0] y_i,
  input  logic signed [CW-1:0] cb_i,
  input  logic signed [CW-1:0] cr_i,
  output logic [PIX_W-1:0]     r_o,
  output logic [PIX_W-1:0]     g_o,
  output logic [PIX_W-1:0]     b_o
);
  localparam int MAXV = (1 << PIX_W) - 1;
  localparam int KY = 1192, KRCR = 1634, KGCB = 401, KGCR = 832, KBCB = 2066;

  function automatic logic [PIX_W-1:0] clip(input int v);
    if (v < 0)    return '0;
    if (v > MAXV) return PIX_W'(MAXV);
    return PIX_W'(v);
  endfunction

  int r_n, g_n, b_n;
  always_comb begin
    r_n = rnd_sh(KY*int'(y_i) + KRCR*int'(cr_i), COEF_FRAC);
    g_n = rnd_sh(KY*int'(y_i) - KGCB*int'(cb_i) - KGCR*int'(cr_i), COEF_FRAC);
    b_n = rnd_sh(KY*int'(y_i) + KBCB*int'(cb_i), COEF_FRAC);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_o <= '0; g_o <= '0; b_o <= '0;
    end else begin
      r_o <= clip(r_n); g_o <= clip(g_n); b_o <= clip(b_n);
    end
  end

  AST_BLACK_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (y_i <= 0 && cb_i == 0 && cr_i == 0) |=> (r_o == 0 && g_o == 0 && b_o == 0)); // R7
endmodule

// File: rtl/cbhs_sync_pipe.sv
module cbhs_sync_pipe #(
  parameter int W     = 3,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] d_o
);
  logic [W-1:0] pipe_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) pipe_q[i] <= '0;
    end else begin
      pipe_q[0] <= d_i;
      for (int i = 1; i < DEPTH; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign d_o = pipe_q[DEPTH-1];
endmodule

// File: rtl/cbhs_adjuster.sv
module cbhs_adjuster #(
  parameter int PIX_W  = 8,
  parameter int CODE_W = 8,
  parameter int BRI_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PIX_W-1:0]  red_i,
  input  logic [PIX_W-1:0]  grn_i,
  input  logic [PIX_W-1:0]  blu_i,
  input  logic              vsync_i,
  input  logic              hsync_i,
  input  logic              de_i,
  input  logic [CODE_W-1:0] contrast_i,
  input  logic [BRI_W-1:0]  bright_i,
  input  logic [CODE_W-1:0] hue_i,
  input  logic [CODE_W-1:0] sat_i,
  output logic [PIX_W-1:0]  red_o,
  output logic [PIX_W-1:0]  grn_o,
  output logic [PIX_W-1:0]  blu_o,
  output logic              vsync_o,
  output logic              hsync_o,
  output logic              de_o
);
  localparam int YW  = PIX_W + 3;
  localparam int CW  = PIX_W + 2;
  localparam int LAT = 4;

  logic signed [YW-1:0] y1, y2, y3;
  logic signed [CW-1:0] cb1, cr1, cb2, cr2, cb3, cr3;
  logic [2:0] flags_d;

  cbhs_rgb2ycc #(.PIX_W(PIX_W), .YW(YW), .CW(CW)) u_fwd (
    .clk_i, .rst_ni, .r_i(red_i), .g_i(grn_i), .b_i(blu_i),
    .y_o(y1), .cb_o(cb1), .cr_o(cr1));

  cbhs_luma_hue #(.YW(YW), .CW(CW), .CODE_W(CODE_W), .BRI_W(BRI_W), .TW(12)) u_lh (
    .clk_i, .rst_ni, .y_i(y1), .cb_i(cb1), .cr_i(cr1),
    .contrast_i, .bright_i, .hue_i,
    .y_o(y2), .cb_o(cb2), .cr_o(cr2));

  cbhs_sat #(.YW(YW), .CW(CW), .CODE_W(CODE_W)) u_sat (
    .clk_i, .rst_ni, .y_i(y2), .cb_i(cb2), .cr_i(cr2), .sat_i,
    .y_o(y3), .cb_o(cb3), .cr_o(cr3));

  cbhs_ycc2rgb #(.PIX_W(PIX_W), .YW(YW), .CW(CW)) u_inv (
    .clk_i, .rst_ni, .y_i(y3), .cb_i(cb3), .cr_i(cr3),
    .r_o(red_o), .g_o(grn_o), .b_o(blu_o));

  cbhs_sync_pipe #(.W(3), .DEPTH(LAT)) u_sync (
    .clk_i, .rst_ni, .d_i({vsync_i, hsync_i, de_i}), .d_o(flags_d));

  assign {vsync_o, hsync_o, de_o} = flags_d;
endmodule

// File: tb/cbhs_adjuster_bench.sv
`timescale 1ns/1ps
module cbhs_adjuster_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] r, g, b, con, hue, sat;
  logic [5:0] bri;
  logic vs, hs, de;
  logic [7:0] ro, go, bo;
  logic vso, hso, deo;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cbhs_adjuster u_cbhs_adjuster (
    .clk_i(clk), .rst_ni(rst_n), .red_i(r), .grn_i(g), .blu_i(b),
    .vsync_i(vs), .hsync_i(hs), .de_i(de),
    .contrast_i(con), .bright_i(bri), .hue_i(hue), .sat_i(sat),
    .red_o(ro), .grn_o(go), .blu_o(bo),
    .vsync_o(vso), .hsync_o(hso), .de_o(deo));

  task automatic chk(input string req, input int act, input int exp, input int tol);
    int d;
    n_chk++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (tol %0d)", req, act, exp, tol);
    end
  endtask

  function automatic int clip_round(input real v);
    if (v < 0.0) return 0;
    if (v > 255.0) return 255;
    return int'(v);
  endfunction

  // real-valued model of R1..R7
  task automatic model(input int ri, input int gi, input int bi, input int c, input int br,
                       input int h, input int s, output int er, output int eg, output int eb);
    real y, cb, cr, th, cb2, cr2;
    y  = 0.2568*ri + 0.5041*gi + 0.0979*bi;
    cb = -0.1482*ri - 0.2910*gi + 0.4392*bi;
    cr = 0.4392*ri - 0.3678*gi - 0.0714*bi;
    y  = y * c / 128.0 + br;
    th = (h - 128) * 30.0 / 128.0 * 3.14159265358979 / 180.0;
    cb2 = cb*$cos(th) + cr*$sin(th);
    cr2 = cr*$cos(th) - cb*$sin(th);
    cb2 = cb2 * s / 128.0;
    cr2 = cr2 * s / 128.0;
    er = clip_round(1.1644*y + 1.5960*cr2);
    eg = clip_round(1.1644*y - 0.3918*cb2 - 0.8130*cr2);
    eb = clip_round(1.1644*y + 2.0172*cb2);
  endtask

  task automatic apply(input int ri, input int gi, input int bi, input int c, input int br,
                       input int h, input int s);
    @(negedge clk);
    r = 8'(ri); g = 8'(gi); b = 8'(bi);
    con = 8'(c); bri = 6'(br); hue = 8'(h); sat = 8'(s);
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_pix(input string req, input int ri, input int gi, input int bi,
                         input int c, input int br, input int h, input int s, input int tol);
    int er, eg, eb;
    apply(ri, gi, bi, c, br, h, s);
    model(ri, gi, bi, c, br, h, s, er, eg, eb);
    chk({req, " red"}, int'(ro), er, tol);
    chk({req, " grn"}, int'(go), eg, tol);
    chk({req, " blu"}, int'(bo), eb, tol);
  endtask

  task automatic t_reset;
    #1;
    chk("R9 red", int'(ro), 0, 0);
    chk("R9 grn", int'(go), 0, 0);
    chk("R9 blu", int'(bo), 0, 0);
    chk("R9 flags", int'({vso, hso, deo}), 0, 0);
  endtask

  task automatic t_grey;  // R1: grey keeps neutral and round-trips
    run_pix("R1 grey128", 128, 128, 128, 128, 0, 128, 128, 1);
    run_pix("R1 grey200", 200, 200, 200, 128, 0, 128, 128, 1);
    run_pix("R1 grey37", 37, 37, 37, 128, 0, 128, 128, 1);
  endtask

  task automatic t_colour;  // R6 unity round trip
    run_pix("R6 orange", 220, 120, 40, 128, 0, 128, 128, 3);
    run_pix("R6 teal", 30, 150, 160, 128, 0, 128, 128, 3);
  endtask

  task automatic t_contrast;
    run_pix("R2 low contrast", 180, 90, 60, 64, 0, 128, 128, 6);
    run_pix("R2 high contrast", 100, 110, 90, 200, 0, 128, 128, 6);
  endtask

  task automatic t_bright;
    run_pix("R3 bright plus", 100, 100, 100, 128, 31, 128, 128, 2);
    run_pix("R3 bright minus", 100, 100, 100, 128, -32, 128, 128, 2);
  endtask

  task automatic t_hue;
    run_pix("R4 hue max", 200, 60, 90, 128, 0, 255, 128, 6);
    run_pix("R4 hue min", 200, 60, 90, 128, 0, 0, 128, 6);
    run_pix("R4 hue small", 60, 90, 200, 128, 0, 160, 128, 6);
  endtask

  task automatic t_sat;
    int er, eg, eb;
    apply(200, 60, 90, 128, 0, 128, 0);
    model(200, 60, 90, 128, 0, 128, 0, er, eg, eb);
    chk("R5 sat zero red=grn", int'(ro), int'(go), 0);
    chk("R5 sat zero grn=blu", int'(go), int'(bo), 0);
    chk("R5 sat zero level", int'(ro), er, 2);
    run_pix("R5 sat double", 150, 100, 110, 128, 0, 128, 255, 6);
  endtask

  task automatic t_clamp;
    apply(255, 255, 255, 255, 31, 128, 128);
    chk("R7 clamp high", int'(ro) + int'(go) + int'(bo), 765, 0);
    apply(0, 0, 0, 128, -32, 128, 128);
    chk("R7 clamp low", int'(ro) + int'(go) + int'(bo), 0, 0);
    run_pix("R7 red overdrive", 250, 10, 10, 128, 0, 128, 255, 6);
  endtask

  task automatic t_latency;
    apply(20, 20, 20, 128, 0, 128, 128);
    vs = 1'b0; hs = 1'b0; de = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    r = 8'd230; g = 8'd230; b = 8'd230; vs = 1'b1; hs = 1'b0; de = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 pixel before 4 cycles", int'(ro), 20, 1);
    chk("R8 flags before 4 cycles", int'({vso, hso, deo}), 0, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R8 pixel at 4 cycles", int'(ro), 230, 1);
    chk("R8 flags at 4 cycles", int'({vso, hso, deo}), 5, 0);
    vs = 1'b0; hs = 1'b1; de = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R8 hsync alone", int'({vso, hso, deo}), 2, 0);
  endtask

  initial begin
    r = '0; g = '0; b = '0; con = 8'd128; bri = '0; hue = 8'd128; sat = 8'd128;
    vs = 1'b1; hs = 1'b1; de = 1'b1;
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    vs = 1'b0; hs = 1'b0; de = 1'b0;
    rst_n = 1'b1;
    t_grey();
    t_colour();
    t_contrast();
    t_bright();
    t_hue();
    t_sat();
    t_clamp();
    t_latency();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule